// File: doc/BRIEF.md
# Round-Robin Hub Access Window Sequencer

This block divides access to a shared memory hub among eight cores by fixed time slots. A free-running 4-bit slot counter steps once per clock; its upper three bits name the core that owns the hub at that moment. A new window opens every two clocks, in ascending core order, so each core sees its own window start once every 16 clocks. The block raises a one-cycle window pulse for the owning core at the start of its slot.

A core that wants a hub operation raises its request line. The sequencer holds that core stalled until the core's next window start, then lets the operation run for a fixed seven clocks and raises a one-cycle done pulse. The wait depends only on the phase of the slot counter when the request arrives. The total latency is therefore 7 to 22 clocks, and no other core's traffic can change it. Because every core owns its own slot, no two operations ever start in the same clock. The memory array and the meaning of each operation lie outside this block.

Top module: `hub_window_seq`

## Requirements
- R1: After reset the slot counter reads 0 in the first cycle and then steps by one every clock, wrapping from 15 to 0. The owner output always equals slot bits [3:1].
- R2: win_o bit k is high exactly in the cycles where the slot counter equals 2k. In odd slots no window bit is high.
- R3: A request from idle core k, sampled in a cycle whose slot value is s, gives a done pulse on done_o bit k in the cycle that comes ((2k - s) mod 16) + 7 clocks later. This latency always lies between 7 and 22 clocks.
- R4: A request sampled in the cycle where the slot value equals 2k waits zero clocks, so done follows exactly 7 clocks later.
- R5: stall_o bit k is high from the cycle after the request is accepted up to and including the done cycle.
- R6: done_o bit k is high for a single cycle. The next window pulse of that core comes exactly 9 clocks after the done cycle.
- R7: A request raised while core k is stalled is ignored. It does not add a done pulse and does not shift the pending one.
- R8: A request held high through the done cycle is accepted in the following cycle. Its latency is then timed by R3 from that cycle.
- R9: When several cores request in the same cycle, each is timed independently by R3. Operations never start in the same cycle.
- R10: During and just after reset, stall_o and done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Per-core hub operation request |
| win_o | output | 8 | Per-core window-start pulse |
| stall_o | output | 8 | Per-core stall while an operation is pending |
| done_o | output | 8 | Per-core one-cycle completion pulse |
| slot_o | output | 4 | Free-running slot counter |
| owner_o | output | 3 | Core that currently owns the hub |

## Verification
The bench runs every core against all 16 counter phases. In each run it measures the exact distance from request to done. A phase off by one, a missing zero-wait case at the window start, or a window decode on the wrong slot bits would show up as a latency off by one clock or by 16 clocks. In each run the bench also raises a second request mid-operation, which exposes a design that restarts or doubles the operation. It then checks the window 9 clocks after done, which catches an execution length that is not fixed. Back-to-back requests held through done, and all eight cores requesting at once, catch a core that locks up after completion and slots that interfere with each other.

// File: rtl/hub_win_pkg.sv
package hub_win_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_EXEC = 2'd2
    } phase_e;

endpackage

// File: rtl/hub_slot_ctr.sv
module hub_slot_ctr #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CNT_W-1:0] slot_o
);

    typedef struct packed {
        logic [CNT_W-1:0] slot;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = st_q.slot + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_o = st_q.slot;

    // R1: the counter advances by exactly one per clock
    assert_slot_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> slot_o == $past(slot_o) + CNT_W'(1));

endmodule

// File: rtl/hub_core_port.sv
module hub_core_port
    import hub_win_pkg::*;
#(
    parameter int unsigned      CNT_W     = 4,
    parameter int unsigned      EXEC_CLKS = 7,
    parameter int unsigned      EXEC_W    = 3,
    parameter logic [CNT_W-1:0] WIN_SLOT  = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic [CNT_W-1:0] slot_i,
    output logic             win_o,
    output logic             stall_o,
    output logic             done_o,
    output logic             start_o
);

    typedef struct packed {
        phase_e            ph;
        logic [EXEC_W-1:0] rem;
    } port_t;

    localparam logic [EXEC_W-1:0] REM_LOAD = EXEC_W'(EXEC_CLKS - 1);

    port_t st_d, st_q;
    logic  win_hit;
    logic  start_c;
    logic  done_c;

    always_comb begin
        st_d    = st_q;
        win_hit = (slot_i == WIN_SLOT);
        start_c = 1'b0;
        done_c  = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    if (win_hit) begin
                        start_c   = 1'b1;
                        st_d.ph   = PH_EXEC;
                        st_d.rem  = REM_LOAD;
                    end else begin
                        st_d.ph   = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (win_hit) begin
                    start_c  = 1'b1;
                    st_d.ph  = PH_EXEC;
                    st_d.rem = REM_LOAD;
                end
            end
            PH_EXEC: begin
                if (st_q.rem == '0) begin
                    done_c  = 1'b1;
                    st_d.ph = PH_IDLE;
                end else begin
                    st_d.rem = st_q.rem - EXEC_W'(1);
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{ph: PH_IDLE, rem: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o   = win_hit;
    assign stall_o = (st_q.ph != PH_IDLE);
    assign done_o  = done_c;
    assign start_o = start_c;

    // R6: completion is a single-cycle pulse
    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: an accepted request stalls the core in the next cycle
    assert_stall_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stall_o && req_i) |=> stall_o);

    // R7: a request during a pending operation does not end the stall early
    assert_ignore_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && !done_o) |=> stall_o);

    // R3: done only ever follows a stalled cycle
    assert_done_stalled_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> stall_o);

endmodule

// File: rtl/hub_window_seq.sv
module hub_window_seq #(
    parameter int unsigned NUM_CORES = 8,
    parameter int unsigned SLOT_CLKS = 2,
    parameter int unsigned EXEC_CLKS = 7
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic [NUM_CORES-1:0]                  req_i,
    output logic [NUM_CORES-1:0]                  win_o,
    output logic [NUM_CORES-1:0]                  stall_o,
    output logic [NUM_CORES-1:0]                  done_o,
    output logic [$clog2(NUM_CORES*SLOT_CLKS)-1:0] slot_o,
    output logic [$clog2(NUM_CORES)-1:0]          owner_o
);

    localparam int unsigned PERIOD = NUM_CORES * SLOT_CLKS;
    localparam int unsigned CNT_W  = $clog2(PERIOD);
    localparam int unsigned OWN_W  = $clog2(NUM_CORES);
    localparam int unsigned EXEC_W = $clog2(EXEC_CLKS + 1);

    logic [CNT_W-1:0]     slot;
    logic [NUM_CORES-1:0] start;

    hub_slot_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .slot_o (slot)
    );

    for (genvar k = 0; k < NUM_CORES; k++) begin : g_port
        hub_core_port #(
            .CNT_W     (CNT_W),
            .EXEC_CLKS (EXEC_CLKS),
            .EXEC_W    (EXEC_W),
            .WIN_SLOT  (CNT_W'(k * SLOT_CLKS))
        ) u_port (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .req_i   (req_i[k]),
            .slot_i  (slot),
            .win_o   (win_o[k]),
            .stall_o (stall_o[k]),
            .done_o  (done_o[k]),
            .start_o (start[k])
        );
    end

    assign slot_o  = slot;
    assign owner_o = slot[CNT_W-1 -: OWN_W];

    // R9: no two operations start in the same clock
    assert_one_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(start));

    // R2: at most one window pulse, and it belongs to the current owner
    assert_win_owner_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(win_o) && ((win_o == '0) || win_o[owner_o]));

    // R9: an operation starts only in the owner's window cycle
    assert_start_in_win_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start & ~win_o) == '0);

endmodule

// File: tb/hub_window_seq_bench.sv
`timescale 1ns/1ps
module hub_window_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req = '0;
    logic [7:0] win, stall, done;
    logic [3:0] slot;
    logic [2:0] owner;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hub_window_seq u_hub_window_seq (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .win_o   (win),
        .stall_o (stall),
        .done_o  (done),
        .slot_o  (slot),
        .owner_o (owner)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_slot(input int p);
        while (int'(slot) != p) @(negedge clk);
    endtask

    // one request from core k at phase p, with a stray request mid-operation
    task automatic run_one(input int k, input int p);
        int exp_n;
        int first;
        int ndone;
        wait_slot(p);
        req[k] = 1'b1;
        exp_n = ((2*k - p) & 15) + 7;
        first = 0;
        ndone = 0;
        for (int n = 1; n <= exp_n + 9; n++) begin
            @(negedge clk);
            if (n == 1) begin
                req[k] = 1'b0;
                chk(stall[k] == 1'b1, "R5 stall after accept", int'(stall[k]), 1);
            end
            if (n == 3) req[k] = 1'b1;
            if (n == 4) req[k] = 1'b0;
            if (done[k]) begin
                ndone++;
                if (first == 0) begin
                    first = n;
                    chk(stall[k] == 1'b1, "R5 stall in done cycle", int'(stall[k]), 1);
                end
            end
            if (n == exp_n + 8)
                chk(win[k] == 1'b0, "R6 no window 8 after done", int'(win[k]), 0);
            if (n == exp_n + 9)
                chk(win[k] == 1'b1, "R6 window 9 after done", int'(win[k]), 1);
        end
        if (p == 2*k)
            chk(first == exp_n, "R4 zero-wait latency", first, exp_n);
        else
            chk(first == exp_n, "R3 latency", first, exp_n);
        chk(ndone == 1, "R7 single done despite stray request", ndone, 1);
    endtask

    // request held through done: re-accepted the next cycle
    task automatic run_b2b(input int k, input int p);
        int exp_n;
        int exp2;
        int s2;
        int n;
        int got2;
        wait_slot(p);
        req[k] = 1'b1;
        exp_n = ((2*k - p) & 15) + 7;
        n = 0;
        while (!done[k] && n < 30) begin
            @(negedge clk);
            n++;
        end
        chk(n == exp_n, "R8 first latency", n, exp_n);
        @(negedge clk);
        s2 = int'(slot);
        exp2 = ((2*k - s2) & 15) + 7;
        @(negedge clk);
        req[k] = 1'b0;
        chk(stall[k] == 1'b1, "R8 re-accepted after done", int'(stall[k]), 1);
        n = 1;
        got2 = 0;
        while (got2 == 0 && n < 30) begin
            if (done[k]) got2 = n;
            else begin
                @(negedge clk);
                n++;
            end
        end
        chk(got2 == exp2, "R8 second latency", got2, exp2);
        @(negedge clk);
    endtask

    // all cores request together at phase p
    task automatic run_all(input int p);
        int first[8];
        wait_slot(p);
        req = 8'hFF;
        for (int k = 0; k < 8; k++) first[k] = 0;
        for (int n = 1; n <= 30; n++) begin
            @(negedge clk);
            if (n == 1) req = '0;
            for (int k = 0; k < 8; k++)
                if (done[k] && first[k] == 0) first[k] = n;
        end
        for (int k = 0; k < 8; k++)
            chk(first[k] == ((2*k - p) & 15) + 7, "R9 concurrent latency",
                first[k], ((2*k - p) & 15) + 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(stall == 8'h00, "R10 stall low in reset", int'(stall), 0);
        chk(done == 8'h00, "R10 done low in reset", int'(done), 0);
        rst_n = 1'b1;
        #0.1;
        chk(slot == 4'd0, "R1 slot 0 after reset", int'(slot), 0);
        chk(win == 8'h01, "R2 core 0 window after reset", int'(win), 1);
        @(negedge clk);
        chk(slot == 4'd1, "R1 slot step", int'(slot), 1);
        for (int c = 0; c < 32; c++) begin
            chk(int'(owner) == int'(slot) >> 1, "R1 owner from slot", int'(owner), int'(slot) >> 1);
            chk(int'(win) == ((slot[0] == 1'b0) ? (1 << (int'(slot) >> 1)) : 0),
                "R2 window decode", int'(win), (slot[0] == 1'b0) ? (1 << (int'(slot) >> 1)) : 0);
            chk(stall == 8'h00 && done == 8'h00, "R10 idle without requests", int'(stall | done), 0);
            @(negedge clk);
            chk(int'(slot) == ((c + 2) & 15), "R1 slot wrap", int'(slot), (c + 2) & 15);
        end
        for (int k = 0; k < 8; k++)
            for (int p = 0; p < 16; p++)
                run_one(k, p);
        run_b2b(0, 0);
        run_b2b(3, 11);
        run_b2b(7, 1);
        run_all(0);
        run_all(5);
        run_all(15);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule